// File: doc/BRIEF.md
# Reservation-Station Dispatch Port Scheduler

This block is the issue stage of an out-of-order core. It keeps a small pool of waiting micro-ops, each tagged with a class and carrying a payload. Each cycle it picks at most one ready micro-op for each of five dispatch ports and sends it to the execution unit behind that port. The five ports are a shared port (index 0), which feeds either the floating-point unit or the second integer unit; a dedicated integer port (1); a load port (2); a store-address port (3); and a store-data port (4). Because port 0 is shared, a cycle can issue either two integer micro-ops, or one integer and one floating-point micro-op, but never two floating-point micro-ops.

Upstream logic writes one micro-op per cycle through the allocate interface. The block reports the slot it will use on `alloc_slot`, so that later operand wakeups can be addressed to that slot. Per-slot wakeup vectors set the two source-ready flags of an entry. A micro-op takes part in selection only once both flags are set. Within each port the oldest eligible entry, by allocation order, wins. A slot is released at the clock edge that ends the cycle in which its micro-op is dispatched. A flush empties the whole station.

Top module: `rs_dispatch_sched`

## Requirements
- R1: After synchronous reset the station is empty: `full` is 0, every `disp_valid` bit is 0 and `alloc_slot` is 0.
- R2: A micro-op is written when `alloc_valid` is high, `full` is low and `flush` is low. It goes into the lowest-numbered free slot, which `alloc_slot` shows during that cycle. `full` is high exactly when all 16 slots are occupied, and an allocation attempted while `full` is high is dropped. Class codes on `alloc_class` are: 0 integer, 1 floating-point, 2 load, 3 store-address, 4 store-data.
- R3: An entry can be dispatched only when both of its source-ready flags are set. A flag is set either by the matching `alloc_rdy_*` bit at allocation or by the matching `wake_*` bit of its slot, and takes effect from the next cycle. Wakeup bits aimed at free slots are ignored.
- R4: Ports 2, 3 and 4 each carry the oldest eligible load, store-address and store-data micro-op respectively. Each of these ports is chosen independently of every other port.
- R5: Port 1 carries the oldest eligible integer micro-op. An integer micro-op reaches port 0 only if port 1 is taken in the same cycle.
- R6: Floating-point micro-ops issue only on port 0. Port 0 carries the oldest entry among the eligible floating-point micro-ops and the eligible integer micro-ops not already sent to port 1. `disp_shared_is_fp` is high when that entry is floating-point.
- R7: A dispatched entry is released at the clock edge ending its dispatch cycle. From the next cycle its slot can be allocated again, and the entry never dispatches a second time.
- R8: While `flush` is high no port dispatches and no allocation is taken. From the next cycle the station is empty.
- R9: Each port issues at most one micro-op per cycle, and no micro-op appears on two ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every entry; suppresses dispatch and allocation this cycle |
| alloc_valid | input | 1 | Allocation request |
| alloc_class | input | 3 | Class code of the incoming micro-op |
| alloc_payload | input | 16 | Opaque micro-op payload |
| alloc_rdy_a | input | 1 | First source already ready |
| alloc_rdy_b | input | 1 | Second source already ready |
| alloc_slot | output | 4 | Slot an allocation in this cycle will occupy |
| full | output | 1 | No free slot |
| wake_a | input | 16 | Per-slot wakeup of the first source |
| wake_b | input | 16 | Per-slot wakeup of the second source |
| disp_valid | output | 5 | Per-port dispatch valid, bit index = port |
| disp_payload | output | 80 | Per-port payload, port p in bits [16p+15:16p] |
| disp_shared_is_fp | output | 1 | Port 0 carries a floating-point micro-op |

## Verification
The functions that most often land in the same cycle are the dispatch and release of an old entry and the allocation of a new one. A flush can arrive in that same cycle, and so can a wakeup for a slot that is not yet occupied. These collisions are forced directly: one phase fills every slot and then wakes them all at once, and another raises flush while an allocation and several ready entries are waiting. A long phase of pseudo-random allocation, wakeup and occasional flush then produces many more overlaps. A behavioural model keeps entries with sequence numbers and computes each port's expected winner by searching for the oldest entry. Its result is compared with every output in every cycle, so a release that happens too early or too late, or an allocation into the wrong slot, shows up as a mismatch on a later cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int PAY_W    = 16;
    localparam int NUM_PORT = 5;
    localparam int NUM_MEM  = 3;

    localparam int P_SHARED = 0;
    localparam int P_INT    = 1;
    localparam int P_MEM0   = 2;

    typedef enum logic [2:0] {
        UC_INT    = 3'd0,
        UC_FP     = 3'd1,
        UC_LOAD   = 3'd2,
        UC_STADDR = 3'd3,
        UC_STDATA = 3'd4
    } uop_class_e;

    typedef struct packed {
        logic             live;
        uop_class_e       cls;
        logic             rdy_a;
        logic             rdy_b;
        logic [PAY_W-1:0] pay;
    } rs_entry_t;

    function automatic uop_class_e mem_port_class(input int m);
        case (m)
            0:       return UC_LOAD;
            1:       return UC_STADDR;
            default: return UC_STDATA;
        endcase
    endfunction
endpackage

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_en,
    input  logic [IDX_W-1:0]            alloc_idx,
    output logic [N_ENT-1:0][N_ENT-1:0] older
);
    // older[i][j] = 1 : slot i was written before slot j
    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < N_ENT; j++) begin
                older[alloc_idx][j] <= 1'b0;
                older[j][alloc_idx] <= (j != int'(alloc_idx));
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N_ENT = 16
) (
    input  logic [N_ENT-1:0]            cand,
    input  logic [N_ENT-1:0][N_ENT-1:0] older,
    output logic [N_ENT-1:0]            grant,
    output logic                        any
);
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < N_ENT; j++) begin
                if (j != i && cand[j] && older[j][i]) beaten = 1'b1;
            end
            grant[i] = cand[i] && !beaten;
        end
    end

    assign any = |cand;
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] live,
    output logic [IDX_W-1:0] idx,
    output logic             none_free
);
    always_comb begin
        idx       = '0;
        none_free = 1'b1;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!live[i]) begin
                idx       = IDX_W'(i);
                none_free = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rs_dispatch_sched.sv
module rs_dispatch_sched
    import rs_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      alloc_valid,
    input  logic [2:0]                alloc_class,
    input  logic [PAY_W-1:0]          alloc_payload,
    input  logic                      alloc_rdy_a,
    input  logic                      alloc_rdy_b,
    output logic [IDX_W-1:0]          alloc_slot,
    output logic                      full,
    input  logic [N_ENT-1:0]          wake_a,
    input  logic [N_ENT-1:0]          wake_b,
    output logic [NUM_PORT-1:0]       disp_valid,
    output logic [NUM_PORT*PAY_W-1:0] disp_payload,
    output logic                      disp_shared_is_fp
);
    rs_entry_t                  ent_q [N_ENT];
    logic [N_ENT-1:0]           live_vec;
    logic [N_ENT-1:0]           elig;
    logic [N_ENT-1:0]           int_cand;
    logic [N_ENT-1:0]           fp_cand;
    logic [N_ENT-1:0]           shared_cand;
    logic [NUM_MEM-1:0][N_ENT-1:0] mem_cand;
    logic [N_ENT-1:0]           ded_grant;
    logic [N_ENT-1:0]           sh_grant;
    logic [NUM_MEM-1:0][N_ENT-1:0] mem_grant;
    logic [NUM_PORT-1:0][N_ENT-1:0] port_grant;
    logic [NUM_PORT-1:0]        port_any;
    logic [N_ENT-1:0]           disp_fire;
    logic [N_ENT-1:0][N_ENT-1:0] older;
    logic                       alloc_fire;

    // ---------------- per-entry eligibility ----------------
    for (genvar i = 0; i < N_ENT; i++) begin : g_elig
        assign live_vec[i] = ent_q[i].live;
        assign elig[i]     = ent_q[i].live && ent_q[i].rdy_a && ent_q[i].rdy_b;
        assign int_cand[i] = elig[i] && (ent_q[i].cls == UC_INT);
        assign fp_cand[i]  = elig[i] && (ent_q[i].cls == UC_FP);
        for (genvar m = 0; m < NUM_MEM; m++) begin : g_mc
            assign mem_cand[m][i] = elig[i] && (ent_q[i].cls == mem_port_class(m));
        end
    end

    // ---------------- allocation slot ----------------
    rs_free_pick #(.N_ENT(N_ENT)) u_free (
        .live      (live_vec),
        .idx       (alloc_slot),
        .none_free (full)
    );

    assign alloc_fire = alloc_valid && !full && !flush;

    rs_age_matrix #(.N_ENT(N_ENT)) u_age (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_fire),
        .alloc_idx (alloc_slot),
        .older     (older)
    );

    // ---------------- port selection ----------------
    // dedicated integer port gets first choice of integer work
    rs_age_pick #(.N_ENT(N_ENT)) u_pick_int (
        .cand  (int_cand),
        .older (older),
        .grant (ded_grant),
        .any   (port_any[P_INT])
    );

    // shared port: floating-point plus integer work left over
    assign shared_cand = fp_cand | (int_cand & ~ded_grant);

    rs_age_pick #(.N_ENT(N_ENT)) u_pick_shared (
        .cand  (shared_cand),
        .older (older),
        .grant (sh_grant),
        .any   (port_any[P_SHARED])
    );

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
        rs_age_pick #(.N_ENT(N_ENT)) u_pick_mem (
            .cand  (mem_cand[m]),
            .older (older),
            .grant (mem_grant[m]),
            .any   (port_any[P_MEM0+m])
        );
    end

    always_comb begin
        port_grant[P_SHARED] = sh_grant;
        port_grant[P_INT]    = ded_grant;
        for (int m = 0; m < NUM_MEM; m++) port_grant[P_MEM0+m] = mem_grant[m];
    end

    // ---------------- dispatch outputs ----------------
    always_comb begin
        disp_fire         = '0;
        disp_shared_is_fp = 1'b0;
        disp_payload      = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            disp_valid[p] = port_any[p] && !flush;
            for (int i = 0; i < N_ENT; i++) begin
                if (port_grant[p][i] && !flush) begin
                    disp_fire[i] = 1'b1;
                    disp_payload[p*PAY_W +: PAY_W] = disp_payload[p*PAY_W +: PAY_W] | ent_q[i].pay;
                end
            end
        end
        for (int i = 0; i < N_ENT; i++) begin
            if (sh_grant[i] && fp_cand[i] && !flush) disp_shared_is_fp = 1'b1;
        end
    end

    // ---------------- entry state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i].live <= 1'b0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (ent_q[i].live && wake_a[i]) ent_q[i].rdy_a <= 1'b1;
                if (ent_q[i].live && wake_b[i]) ent_q[i].rdy_b <= 1'b1;
                if (disp_fire[i]) ent_q[i].live <= 1'b0;
                if (alloc_fire && (int'(alloc_slot) == i)) begin
                    ent_q[i].live  <= 1'b1;
                    ent_q[i].cls   <= uop_class_e'(alloc_class);
                    ent_q[i].rdy_a <= alloc_rdy_a;
                    ent_q[i].rdy_b <= alloc_rdy_b;
                    ent_q[i].pay   <= alloc_payload;
                end
            end
        end
    end
endmodule

// File: rtl/rs_dispatch_sched_chk.sv
module rs_dispatch_sched_chk #(
    parameter int N_ENT = 16,
    parameter int NUM_PORT = 5,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                alloc_valid,
    input logic [IDX_W-1:0]    alloc_slot,
    input logic                full,
    input logic [NUM_PORT-1:0] disp_valid,
    input logic                disp_shared_is_fp,
    input logic [N_ENT-1:0]    live_vec
);
    // R2: an accepted allocation occupies the slot it announced
    a_r2_alloc_lands: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !full && !flush) |=> live_vec[$past(alloc_slot)]);

    // R5: integer work on the shared port only when the dedicated port is busy
    a_r5_int_pair: assert property (@(posedge clk) disable iff (rst)
        (disp_valid[0] && !disp_shared_is_fp) |-> disp_valid[1]);

    // R6: floating-point flag only with a shared-port dispatch
    a_r6_fp_flag: assert property (@(posedge clk) disable iff (rst)
        disp_shared_is_fp |-> disp_valid[0]);

    // R7: any dispatch leaves room for the next cycle
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (disp_valid != '0) |=> !full);

    // R8: flush silences dispatch and empties the station
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        flush |-> (disp_valid == '0));
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (live_vec == '0));

    // R9: never more dispatches than occupied entries
    a_r9_per_entry: assert property (@(posedge clk) disable iff (rst)
        $countones(disp_valid) <= $countones(live_vec));
endmodule

bind rs_dispatch_sched rs_dispatch_sched_chk #(.N_ENT(N_ENT), .NUM_PORT(rs_pkg::NUM_PORT)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .flush             (flush),
    .alloc_valid       (alloc_valid),
    .alloc_slot        (alloc_slot),
    .full              (full),
    .disp_valid        (disp_valid),
    .disp_shared_is_fp (disp_shared_is_fp),
    .live_vec          (live_vec)
);

// File: tb/sim_rs_dispatch_sched.sv
`timescale 1ns/1ps
module sim_rs_dispatch_sched;
    localparam int N  = 16;
    localparam int PW = 16;
    localparam int NP = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           flush = 1'b0;
    logic           alloc_valid = 1'b0;
    logic [2:0]     alloc_class = '0;
    logic [PW-1:0]  alloc_payload = '0;
    logic           alloc_rdy_a = 1'b0;
    logic           alloc_rdy_b = 1'b0;
    logic [3:0]     alloc_slot;
    logic           full;
    logic [N-1:0]   wake_a = '0;
    logic [N-1:0]   wake_b = '0;
    logic [NP-1:0]  disp_valid;
    logic [NP*PW-1:0] disp_payload;
    logic           disp_shared_is_fp;

    always #5 clk = ~clk;

    rs_dispatch_sched u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_class(alloc_class),
        .alloc_payload(alloc_payload), .alloc_rdy_a(alloc_rdy_a),
        .alloc_rdy_b(alloc_rdy_b), .alloc_slot(alloc_slot), .full(full),
        .wake_a(wake_a), .wake_b(wake_b), .disp_valid(disp_valid),
        .disp_payload(disp_payload), .disp_shared_is_fp(disp_shared_is_fp)
    );

    // ---------------- reference model ----------------
    bit  m_live [N];
    int  m_cls  [N];
    bit  m_ra   [N];
    bit  m_rb   [N];
    int  m_pay  [N];
    int  m_seq  [N];
    int  seq_ctr = 0;
    int  pay_ctr = 1;

    int  n_cmp = 0;
    int  n_bad = 0;
    string tag = "R1";

    function automatic bit ready(int i);
        return m_live[i] && m_ra[i] && m_rb[i];
    endfunction

    function automatic int oldest(int cls_a, int cls_b, int skip);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (ready(i) && i != skip && (m_cls[i] == cls_a || m_cls[i] == cls_b)) begin
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
            end
        end
        return best;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit al, int cls, bit ra, bit rb,
                        logic [N-1:0] wa, logic [N-1:0] wb, bit fl);
        int  pick [NP];
        int  mfree;
        bit  mfull;
        @(negedge clk);
        alloc_valid   = al;
        alloc_class   = 3'(cls);
        alloc_payload = PW'(pay_ctr);
        alloc_rdy_a   = ra;
        alloc_rdy_b   = rb;
        wake_a        = wa;
        wake_b        = wb;
        flush         = fl;
        #1;
        // expected winners
        pick[1] = oldest(0, 0, -1);
        pick[0] = oldest(1, 0, pick[1]);
        pick[2] = oldest(2, 2, -1);
        pick[3] = oldest(3, 3, -1);
        pick[4] = oldest(4, 4, -1);
        if (fl) for (int p = 0; p < NP; p++) pick[p] = -1;
        mfree = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_live[i]) mfree = i;
        mfull = (mfree < 0);

        chk("R2 full", int'(full), int'(mfull));
        if (!mfull) chk("R2 alloc_slot", int'(alloc_slot), mfree);
        for (int p = 0; p < NP; p++) begin
            chk($sformatf("R9 port%0d valid (R4/R5/R6/R8)", p), int'(disp_valid[p]), int'(pick[p] >= 0));
            if (pick[p] >= 0 && disp_valid[p])
                chk($sformatf("port%0d payload (R4/R5/R6)", p),
                    int'(disp_payload[p*PW +: PW]), m_pay[pick[p]]);
        end
        if (pick[0] >= 0)
            chk("R6 shared_is_fp", int'(disp_shared_is_fp), int'(m_cls[pick[0]] == 1));

        // next state
        if (fl) begin
            for (int i = 0; i < N; i++) m_live[i] = 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_live[i] && wa[i]) m_ra[i] = 1'b1;
                if (m_live[i] && wb[i]) m_rb[i] = 1'b1;
            end
            for (int p = 0; p < NP; p++) if (pick[p] >= 0) m_live[pick[p]] = 1'b0;
            if (al && !mfull) begin
                m_live[mfree] = 1'b1;
                m_cls[mfree]  = cls;
                m_ra[mfree]   = ra;
                m_rb[mfree]   = rb;
                m_pay[mfree]  = pay_ctr;
                m_seq[mfree]  = seq_ctr;
                seq_ctr++;
            end
        end
        pay_ctr = (pay_ctr + 1) & 16'hFFFF;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, '0, '0, 0);
    endtask

    task automatic put(int cls, bit ra, bit rb);
        step(1, cls, ra, rb, '0, '0, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL [watchdog] run did not finish: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 0; m_cls[i] = 0; m_ra[i] = 0; m_rb[i] = 0; m_pay[i] = 0; m_seq[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        tag = "R1 reset";
        idle(2);

        // R3: readiness needs both flags; wakeups to free slots ignored
        tag = "R3 wakeup";
        put(0, 0, 0);
        put(2, 1, 0);
        put(1, 0, 1);
        step(0, 0, 0, 0, 16'h00F8, 16'h00F8, 0);   // free slots: ignored
        step(0, 0, 0, 0, 16'h0001, 16'h0000, 0);   // slot0 only half ready
        idle(1);
        step(0, 0, 0, 0, 16'h0004, 16'h0003, 0);   // all three become ready
        idle(3);

        // R2: fill, blocked allocation while full, then mass wakeup (R5)
        tag = "R2 fill";
        for (int k = 0; k < N; k++) put(0, 0, 0);
        put(1, 1, 1);                              // dropped: full
        idle(1);
        tag = "R5 drain";
        step(0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 0);
        idle(10);

        // R6: FP/INT mix, oldest wins shared port
        tag = "R6 mix";
        put(1, 0, 0); put(0, 0, 0); put(0, 0, 0); put(1, 0, 0); put(0, 0, 0); put(1, 0, 0);
        step(0, 0, 0, 0, 16'h003F, 16'h003F, 0);
        idle(6);
        put(0, 0, 0); put(0, 0, 0); put(0, 0, 0); put(1, 0, 0);
        step(0, 0, 0, 0, 16'h000F, 16'h000F, 0);
        idle(4);

        // R4: memory ports independent and oldest-first
        tag = "R4 mem";
        put(3, 0, 0); put(2, 0, 0); put(4, 0, 0); put(2, 0, 0); put(3, 0, 0); put(4, 0, 0); put(0, 0, 0);
        step(0, 0, 0, 0, 16'h007F, 16'h007F, 0);
        idle(4);

        // R7: immediate reuse of released slots
        tag = "R7 reuse";
        for (int k = 0; k < 8; k++) put(k % 5, 1, 1);
        idle(3);

        // R8: flush with pending work and a simultaneous allocation
        tag = "R8 flush";
        put(0, 1, 1); put(1, 1, 1); put(2, 0, 0); put(0, 0, 1);
        step(1, 3, 1, 1, 16'h000F, 16'h000F, 1);
        idle(2);
        put(4, 1, 1);
        idle(2);

        // R9: pseudo-random traffic
        tag = "R9 random";
        void'($urandom(32'h1234));
        for (int k = 0; k < 3000; k++) begin
            step($urandom_range(0, 9) < 6, $urandom_range(0, 4),
                 $urandom_range(0, 1), $urandom_range(0, 1),
                 N'($urandom & $urandom), N'($urandom & $urandom),
                 $urandom_range(0, 199) == 0);
        end
        idle(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule